// File: doc/BRIEF.md
# Indexed Command Queue with Matched Response Slots

This block sits between a host and a serial sensor-bus transmitter. The host places 16-bit commands into four numbered slots. Each command is held as a high byte (bits 15:8) and a low byte (bits 7:0). A scheduler offers one pending slot at a time to the transmitter over a valid/ready handshake. The transmitter later returns a response made of 16 data bits and an 8-bit status byte, tagged with the slot index. The response is stored in the receive slot that has the same index as the command that produced it.

Each slot moves from free to pending on a host write. It moves from pending to in flight when the transmitter accepts the command. It returns to free when its response is stored. A host write is accepted only while the addressed slot is free. Any other write is dropped and raises a sticky overrun flag. When several slots are pending, the scheduler scans forward cyclically from the slot after the last one dispatched and skips empty slots. When nothing is pending, its scan origin falls back to slot 0. The host reads a response by index, and the data word and the status byte come back in the same read.

Top module: `slot_q_top`

## Requirements
- R1: Each of the four slots holds a 16-bit command, with the high byte in bits 15:8 and the low byte in bits 7:0. While the slot is offered, `tx_cmd_o` presents the command exactly as written.
- R2: A write to a free slot is accepted. In the next cycle the slot is pending and `tx_valid_o` is 1.
- R3: A write to a slot that is pending or in flight is dropped and leaves the stored command unchanged. It sets `overrun_o` from the next cycle, and `overrun_o` stays set until reset.
- R4: When no slot is pending, the scan origin returns to slot 0. With nothing dispatched since then, the offered slot is the lowest-numbered pending slot.
- R5: After a handshake on slot k, the next slot offered is the first pending slot found scanning k+1, k+2, … modulo 4. Empty slots are skipped, even when a lower-numbered slot is also pending.
- R6: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_idx_o` and `tx_cmd_o` stay unchanged and `tx_valid_o` stays 1.
- R7: A slot stops being pending in the cycle after its handshake. It is not offered again until it has been rewritten.
- R8: A response whose `rsp_idx_i` names a slot that is in flight is stored in the receive slot with that index. From the next cycle, `rd_vld_o`, `rd_data_o` and `rd_stat_o` show it for that `rd_idx_i`. A response naming a slot that is not in flight is ignored.
- R9: The status byte is stored whole, with bit 0 used as the error flag. It is returned in the same read as its data word.
- R10: An accepted write to a slot clears that slot's response-valid flag from the next cycle.
- R11: While `rst_ni` is 0, all pending and response-valid flags clear, `overrun_o` clears, no slot is offered, and the scan origin returns to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host command write strobe |
| wr_idx_i | input | 2 | Slot addressed by the write |
| wr_cmd_i | input | 16 | Command word (high byte 15:8, low byte 7:0) |
| overrun_o | output | 1 | Sticky flag for a dropped write |
| tx_valid_o | output | 1 | A command is offered to the transmitter |
| tx_ready_i | input | 1 | Transmitter accepts the offered command |
| tx_idx_o | output | 2 | Slot index of the offered command |
| tx_cmd_o | output | 16 | Offered command word |
| rsp_valid_i | input | 1 | Response strobe from the transmitter |
| rsp_idx_i | input | 2 | Slot index the response belongs to |
| rsp_data_i | input | 16 | Response data word |
| rsp_stat_i | input | 8 | Response status byte, bit 0 is the error flag |
| rd_idx_i | input | 2 | Receive slot selected for reading |
| rd_vld_o | output | 1 | Selected receive slot holds a response |
| rd_data_o | output | 16 | Data word of the selected response |
| rd_stat_o | output | 8 | Status byte of the selected response |

## Verification
Every result is due one clock edge after its cause. A write becomes an offer in the next cycle. A handshake moves the offer to the next slot in the next cycle. A stored response, a cleared response flag and the overrun flag all appear right after the edge that captures the stimulus. Stimulus changes on the falling edge. The scoreboard monitor samples each handshake a quarter period after that, while `tx_ready_i` is stable and before the rising edge that completes the transfer. Direct checks of the read port and flags are made just after the falling edge that follows the capturing edge.

// File: rtl/slot_q_pkg.sv
package slot_q_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE   = 2'd0,
    SLOT_PEND   = 2'd1,
    SLOT_FLIGHT = 2'd2
  } slot_st_e;
endpackage

// File: rtl/slot_q_slot.sv
module slot_q_slot
  import slot_q_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hit_i,
  input  logic [CMD_W-1:0] wr_cmd_i,
  input  logic             take_i,
  input  logic             rsp_hit_i,
  output logic             wr_ok_o,
  output logic             free_o,
  output logic             pend_o,
  output logic             flight_o,
  output logic [CMD_W-1:0] cmd_o
);
  slot_st_e         st_q;
  logic [CMD_W-1:0] cmd_q;

  assign free_o   = (st_q == SLOT_FREE);
  assign pend_o   = (st_q == SLOT_PEND);
  assign flight_o = (st_q == SLOT_FLIGHT);
  assign wr_ok_o  = wr_hit_i && free_o;
  assign cmd_o    = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SLOT_FREE;
      cmd_q <= '0;
    end else begin
      unique case (st_q)
        SLOT_FREE: if (wr_hit_i) begin
          st_q  <= SLOT_PEND;
          cmd_q <= wr_cmd_i;
        end
        SLOT_PEND:   if (take_i)    st_q <= SLOT_FLIGHT;
        SLOT_FLIGHT: if (rsp_hit_i) st_q <= SLOT_FREE;
        default:     st_q <= SLOT_FREE;
      endcase
    end
  end

  // R7: flight is entered only through a handshake on a pending slot
  a_r7_flight_from_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flight_o && !$past(flight_o)) |-> $past(pend_o && take_i));

  // R3: a busy slot keeps its command
  a_r3_cmd_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && !free_o) |=> $stable(cmd_o));
endmodule

// File: rtl/slot_q_pick.sv
module slot_q_pick #(
  parameter int SLOTS = 4,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] pend_i,
  input  logic             tx_ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] ptr_q, hold_idx_q, scan_idx;
  logic             hold_q, found;

  // cyclic scan from ptr_q; SLOTS is a power of two so the index wraps
  always_comb begin
    logic [IDX_W-1:0] cand;
    found    = 1'b0;
    scan_idx = ptr_q;
    for (int i = 0; i < SLOTS; i++) begin
      cand = ptr_q + IDX_W'(i);
      if (!found && pend_i[cand]) begin
        found    = 1'b1;
        scan_idx = cand;
      end
    end
  end

  assign valid_o = hold_q || found;
  assign idx_o   = hold_q ? hold_idx_q : scan_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (valid_o && tx_ready_i) begin
      ptr_q  <= idx_o + IDX_W'(1);
      hold_q <= 1'b0;
    end else if (valid_o) begin
      hold_q     <= 1'b1;
      hold_idx_q <= idx_o;
    end else begin
      ptr_q <= '0;
    end
  end

  function automatic logic [IDX_W-1:0] lowest(input logic [SLOTS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = SLOTS - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // R6: offer is held while stalled
  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !tx_ready_i) |=> (valid_o && $stable(idx_o)));

  // R4: first offer after an idle cycle is the lowest pending slot
  a_r4_lowest_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(valid_o) && valid_o) |-> (idx_o == lowest(pend_i)));
endmodule

// File: rtl/slot_q_rsp.sv
module slot_q_rsp #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 16,
  parameter int STAT_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [SLOTS-1:0]  clr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] rd_stat_o
);
  logic [SLOTS-1:0]  vld_q;
  logic [DATA_W-1:0] data_q [SLOTS];
  logic [STAT_W-1:0] stat_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_rx
    logic hit;
    assign hit = store_i && (st_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        data_q[g] <= '0;
        stat_q[g] <= '0;
      end else if (hit) begin
        vld_q[g]  <= 1'b1;
        data_q[g] <= data_i;
        stat_q[g] <= stat_i;
      end else if (clr_i[g]) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];
  assign rd_stat_o = stat_q[rd_idx_i];

  // R10: an accepted write leaves that slot without a response
  a_r10_clear_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i && !store_i) |=> ((vld_q & $past(clr_i)) == '0));
endmodule

// File: rtl/slot_q_top.sv
module slot_q_top #(
  parameter int SLOTS  = 4,
  parameter int CMD_W  = 16,
  parameter int DATA_W = 16,
  parameter int STAT_W = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CMD_W-1:0]  wr_cmd_i,
  output logic              overrun_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [CMD_W-1:0]  tx_cmd_o,
  input  logic              rsp_valid_i,
  input  logic [IDX_W-1:0]  rsp_idx_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [STAT_W-1:0] rsp_stat_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] rd_stat_o
);
  logic [SLOTS-1:0] free_v, pend_v, flight_v, wr_ok_v;
  logic [CMD_W-1:0] cmd_v [SLOTS];
  logic             store, overrun_q, tx_fire;

  assign tx_fire = tx_valid_o && tx_ready_i;
  assign store   = rsp_valid_i && flight_v[rsp_idx_i];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    slot_q_slot #(.CMD_W(CMD_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_hit_i (wr_en_i && (wr_idx_i == IDX_W'(g))),
      .wr_cmd_i (wr_cmd_i),
      .take_i   (tx_fire && (tx_idx_o == IDX_W'(g))),
      .rsp_hit_i(store && (rsp_idx_i == IDX_W'(g))),
      .wr_ok_o  (wr_ok_v[g]),
      .free_o   (free_v[g]),
      .pend_o   (pend_v[g]),
      .flight_o (flight_v[g]),
      .cmd_o    (cmd_v[g])
    );
  end

  slot_q_pick #(.SLOTS(SLOTS)) u_pick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend_v),
    .tx_ready_i(tx_ready_i),
    .valid_o   (tx_valid_o),
    .idx_o     (tx_idx_o)
  );

  assign tx_cmd_o = cmd_v[tx_idx_o];

  slot_q_rsp #(.SLOTS(SLOTS), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_rsp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .store_i  (store),
    .st_idx_i (rsp_idx_i),
    .data_i   (rsp_data_i),
    .stat_i   (rsp_stat_i),
    .clr_i    (wr_ok_v),
    .rd_idx_i (rd_idx_i),
    .rd_vld_o (rd_vld_o),
    .rd_data_o(rd_data_o),
    .rd_stat_o(rd_stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          overrun_q <= 1'b0;
    else if (wr_en_i && !free_v[wr_idx_i]) overrun_q <= 1'b1;
  end
  assign overrun_o = overrun_q;

  // R3: sticky until reset
  a_r3_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R3: a write to a busy slot raises the flag
  a_r3_reject_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (pend_v[wr_idx_i] || flight_v[wr_idx_i])) |=> overrun_o);

  // R7: handshake moves the slot out of pending
  a_r7_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fire |=> !pend_v[$past(tx_idx_o)]);

  // R8: a stored response becomes readable
  a_r8_store_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && rd_idx_i == rsp_idx_i && $stable(rd_idx_i)) |=>
      (($past(rd_idx_i) != rd_idx_i) || (rd_vld_o && rd_data_o == $past(rsp_data_i))));
endmodule

// File: tb/slot_q_top_test.sv
module slot_q_top_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rdy = 1'b0, rsp_v = 1'b0;
  logic [1:0]  wr_idx = '0, rsp_idx = '0, rd_idx = '0;
  logic [15:0] wr_cmd = '0, rsp_data = '0;
  logic [7:0]  rsp_stat = '0;
  logic        overrun, tx_valid, rd_vld;
  logic [1:0]  tx_idx;
  logic [15:0] tx_cmd, rd_data;
  logic [7:0]  rd_stat;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct packed { logic [1:0] idx; logic [15:0] cmd; } exp_t;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  slot_q_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_cmd_i(wr_cmd), .overrun_o(overrun),
    .tx_valid_o(tx_valid), .tx_ready_i(rdy), .tx_idx_o(tx_idx), .tx_cmd_o(tx_cmd),
    .rsp_valid_i(rsp_v), .rsp_idx_i(rsp_idx), .rsp_data_i(rsp_data), .rsp_stat_i(rsp_stat),
    .rd_idx_i(rd_idx), .rd_vld_o(rd_vld), .rd_data_o(rd_data), .rd_stat_o(rd_stat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: handshakes against the expected dispatch order (R1, R5, R7)
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && tx_valid && rdy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected dispatch", {14'd0, tx_idx, tx_cmd}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(tx_idx == e.idx, "R5 dispatch index", 32'(tx_idx), 32'(e.idx));
        chk(tx_cmd == e.cmd, "R1 dispatch command", 32'(tx_cmd), 32'(e.cmd));
      end
    end
  end

  task automatic push(input logic [1:0] i, input logic [15:0] c);
    exp_q.push_back({i, c});
  endtask

  task automatic host_wr(input logic [1:0] i, input logic [15:0] c);
    @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_cmd = c;
    @(negedge clk); wr_en = 1'b0;
    #1;
  endtask

  task automatic send_rsp(input logic [1:0] i, input logic [15:0] d, input logic [7:0] s);
    @(negedge clk); rsp_v = 1'b1; rsp_idx = i; rsp_data = d; rsp_stat = s;
    @(negedge clk); rsp_v = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input logic [1:0] i, input bit v, input logic [15:0] d, input logic [7:0] s, input string tag);
    rd_idx = i; #1;
    chk(rd_vld == v, {tag, " valid"}, 32'(rd_vld), 32'(v));
    if (v) begin
      chk(rd_data == d, {tag, " data"}, 32'(rd_data), 32'(d));
      chk(rd_stat == s, {tag, " status"}, 32'(rd_stat), 32'(s));
    end
  endtask

  task automatic drain();
    for (int n = 0; n < 100 && exp_q.size() != 0; n++) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    // R11 reset state
    chk(!tx_valid, "R11 no offer after reset", 32'(tx_valid), 0);
    chk(!overrun, "R11 overrun clear", 32'(overrun), 0);
    for (int i = 0; i < 4; i++) rd_chk(2'(i), 1'b0, '0, '0, "R11 rx slot empty");

    // R1 R2 R4 R6: first written slot offered next cycle, then held while stalled
    host_wr(2'd1, 16'hA1B1);
    chk(tx_valid, "R2 offer after write", 32'(tx_valid), 1);
    chk(tx_idx == 2'd1, "R4 offered slot", 32'(tx_idx), 1);
    chk(tx_cmd == 16'hA1B1, "R1 command bytes", 32'(tx_cmd), 32'hA1B1);
    host_wr(2'd3, 16'hA3B3);
    host_wr(2'd2, 16'hA2B2);
    chk(tx_idx == 2'd1 && tx_cmd == 16'hA1B1, "R6 held while stalled", 32'(tx_idx), 1);
    push(2'd1, 16'hA1B1); push(2'd2, 16'hA2B2); push(2'd3, 16'hA3B3);
    @(negedge clk); rdy = 1'b1;
    drain();
    chk(!tx_valid, "R7 nothing pending after dispatch", 32'(tx_valid), 0);

    // R3 write to in-flight slot
    host_wr(2'd2, 16'hDEAD);
    chk(overrun, "R3 overrun on in-flight write", 32'(overrun), 1);
    repeat (3) @(negedge clk); #1;
    chk(overrun, "R3 overrun sticky", 32'(overrun), 1);
    chk(!tx_valid, "R3 rejected write not offered", 32'(tx_valid), 0);

    // R8 R9 responses
    send_rsp(2'd0, 16'h5555, 8'h00);
    rd_chk(2'd0, 1'b0, '0, '0, "R8 stray response ignored");
    send_rsp(2'd2, 16'h1234, 8'h81);
    rd_chk(2'd2, 1'b1, 16'h1234, 8'h81, "R9 response with error bit");
    send_rsp(2'd1, 16'h4321, 8'h00);
    send_rsp(2'd3, 16'hBEEF, 8'h10);
    rd_chk(2'd1, 1'b1, 16'h4321, 8'h00, "R8 slot 1 response");
    rd_chk(2'd3, 1'b1, 16'hBEEF, 8'h10, "R8 slot 3 response");

    // R10 rewrite clears response flag (ready still high: dispatches at once)
    push(2'd2, 16'hC2C2);
    host_wr(2'd2, 16'hC2C2);
    rd_chk(2'd2, 1'b0, '0, '0, "R10 response flag cleared");
    drain();
    send_rsp(2'd2, 16'h0F0F, 8'h02);
    rd_chk(2'd2, 1'b1, 16'h0F0F, 8'h02, "R8 slot 2 second response");

    // R5 cyclic scan with skip: order 1, 2, 0 (3 empty)
    @(negedge clk); rdy = 1'b0;
    host_wr(2'd1, 16'h1111);
    host_wr(2'd2, 16'h2222);
    push(2'd1, 16'h1111);
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); rdy = 1'b0;
    host_wr(2'd0, 16'h0000);
    chk(tx_idx == 2'd2, "R5 scan continues after last dispatch", 32'(tx_idx), 2);
    push(2'd2, 16'h2222); push(2'd0, 16'h0000);
    @(negedge clk); rdy = 1'b1;
    drain();
    send_rsp(2'd1, 16'h0001, 8'h00);
    send_rsp(2'd2, 16'h0002, 8'h00);
    send_rsp(2'd0, 16'h0003, 8'h00);
    rd_chk(2'd0, 1'b1, 16'h0003, 8'h00, "R8 wrapped slot response");

    // R11 reset with a pending slot and stored responses
    @(negedge clk); rdy = 1'b0;
    host_wr(2'd3, 16'h3333);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #1;
    chk(!tx_valid, "R11 pending cleared by reset", 32'(tx_valid), 0);
    chk(!overrun, "R11 overrun cleared by reset", 32'(overrun), 0);
    rd_chk(2'd1, 1'b0, '0, '0, "R11 response flag cleared");

    // R3 write to pending slot leaves command unchanged
    host_wr(2'd3, 16'h7A7A);
    host_wr(2'd3, 16'h6B6B);
    chk(overrun, "R3 overrun on pending write", 32'(overrun), 1);
    push(2'd3, 16'h7A7A);
    @(negedge clk); rdy = 1'b1;
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule